// File: doc/BRIEF.md
# Banked cache hit-latency pipeline

This block sits between a coalesced memory-access queue and a banked data-cache lookup. On each cycle it looks at up to one window of pending requests, chooses a cache bank for each from address bits, and writes each request into the entry slot of that bank's fixed-length delay line. Every bank's delay line models the cache hit latency. The request that reaches the head slot of a bank is offered to that bank's lookup port. The lookup answers with hit, miss or reservation-fail.

Hit and miss retire the head entry. A reservation failure keeps the entry in place so it is retried on the next cycle, and the entries behind it pile up into the free slots. On the issue side the block reports how many requests it took in this cycle. It also reports whether issue stopped on a bank collision or whether work is still left in the queue. A counter tracks how many store acknowledgements are still outstanding.

Top module: `bank_hit_delay`

## Requirements
- R1: Bank selection uses address bits `[SECTOR_LOG2 +: log2(NUM_BANKS)]` when `SECTOR_MODE` is 1 and `[LINE_LOG2 +: log2(NUM_BANKS)]` when it is 0.
- R2: A request accepted at a clock edge appears at the head of its bank (`lk_valid` high, with its tag and address) after exactly `LATENCY` edges, counting the accepting edge, when nothing ahead of it is blocked.
- R3: Lanes are taken strictly in order from lane 0. Up to `NUM_BANKS` of them can be taken in one cycle. `req_ready` is a prefix of the valid lanes, and `acc_count` equals its population count.
- R4: A lane is refused if its bank's entry slot holds an entry from an earlier cycle or was claimed by an earlier lane in the same cycle. That lane and all lanes after it are then not accepted, and `issue_stall` reads 1 (bank conflict).
- R5: `issue_stall` reads 2 (coalescing stall) when there was no conflict, all `NUM_BANKS` lanes were accepted and `req_backlog` is high. Otherwise, when there is no conflict, it reads 0.
- R6: The lookup status encoding is 0 = hit, 1 = miss, 2 = reservation fail. A head entry with status hit or miss is removed at the next edge. A head entry with status reservation fail stays at the head with the same tag.
- R7: Inside a bank an entry moves forward only into a vacant slot. With the head blocked, later entries fill the line in arrival order with no loss, and after release they reach the head on consecutive cycles in that order.
- R8: `store_pend` rises for each accepted store, by `size >> SECTOR_LOG2` in sector mode and by 1 in line mode. It falls by the same amount only when a store head gets status hit with `lk_wr_sent` low. A miss, or a hit that sends a write, leaves it unchanged.
- R9: After reset all delay lines are empty, `lk_valid` is 0, `store_pend` is 0, and `issue_stall` is 0 when no lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_BANKS | Valid per request lane, contiguous from lane 0 |
| req_addr | input | NUM_BANKS*ADDR_W | Byte address per lane |
| req_tag | input | NUM_BANKS*TAG_W | Request identifier per lane |
| req_store | input | NUM_BANKS | Lane carries a store |
| req_size | input | NUM_BANKS*SIZE_W | Store data size in bytes per lane |
| req_backlog | input | 1 | Queue holds more entries than the presented lanes |
| req_ready | output | NUM_BANKS | Lane accepted this cycle |
| acc_count | output | $clog2(NUM_BANKS+1) | Number of lanes accepted (pop count for the queue) |
| issue_stall | output | 2 | 0 none, 1 bank conflict, 2 coalescing stall |
| lk_valid | output | NUM_BANKS | Head slot of the bank holds a request |
| lk_addr | output | NUM_BANKS*ADDR_W | Head request address per bank |
| lk_tag | output | NUM_BANKS*TAG_W | Head request tag per bank |
| lk_store | output | NUM_BANKS | Head request is a store |
| lk_status | input | NUM_BANKS*2 | Lookup result per bank |
| lk_wr_sent | input | NUM_BANKS | Lookup sent a write for the head store |
| store_pend | output | CNT_W | Outstanding store acknowledgement count |

## Verification
A store can be accepted in the same cycle in which another store retires with a hit and no write. The counter must then add the issue amount and subtract the retire amount together. Issue into a bank's entry slot can also meet that bank's head shifting out. The bench keeps a head stuck on reservation fail while it keeps offering a fourth request to that bank, which must see a conflict on every cycle. It then releases the head and checks that the held entries reach the head one per cycle in their arrival order, with the counter matching the amounts worked out by hand.

// File: rtl/bhd_pkg.sv
package bhd_pkg;
   typedef enum logic [1:0] {
      LK_HIT     = 2'd0,
      LK_MISS    = 2'd1,
      LK_RSVFAIL = 2'd2
   } lk_status_e;

   typedef enum logic [1:0] {
      ST_NONE     = 2'd0,
      ST_CONFLICT = 2'd1,
      ST_COAL     = 2'd2
   } stall_e;
endpackage

// File: rtl/bhd_bank_sel.sv
module bhd_bank_sel #(
   parameter int ADDR_W      = 16,
   parameter int NUM_BANKS   = 4,
   parameter int SECTOR_MODE = 1,
   parameter int SECTOR_LOG2 = 5,
   parameter int LINE_LOG2   = 7
) (
   input  logic [ADDR_W-1:0]            addr,
   output logic [$clog2(NUM_BANKS)-1:0] bank
);
   localparam int BW = $clog2(NUM_BANKS);

   generate
      if (SECTOR_MODE != 0) begin : g_sector
         assign bank = addr[SECTOR_LOG2 +: BW];
      end else begin : g_line
         assign bank = addr[LINE_LOG2 +: BW];
      end
   endgenerate
endmodule

// File: rtl/bhd_issue.sv
module bhd_issue
   import bhd_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input  logic [NUM_BANKS-1:0]                   lane_valid,
   input  logic [NUM_BANKS*$clog2(NUM_BANKS)-1:0] lane_bank,
   input  logic [NUM_BANKS-1:0]                   entry_free,
   input  logic                                   backlog,
   output logic [NUM_BANKS-1:0]                   lane_ready,
   output logic [$clog2(NUM_BANKS+1)-1:0]         accepted,
   output logic [1:0]                             stall,
   output logic [NUM_BANKS-1:0]                   bank_push,
   output logic [NUM_BANKS*$clog2(NUM_BANKS)-1:0] bank_lane
);
   localparam int BW = $clog2(NUM_BANKS);
   localparam int CW = $clog2(NUM_BANKS+1);

   logic conflict;

   always_comb begin
      logic             stop;
      logic [NUM_BANKS-1:0] taken;
      logic [BW-1:0]    b;
      lane_ready = '0;
      bank_push  = '0;
      bank_lane  = '0;
      accepted   = '0;
      conflict   = 1'b0;
      stop       = 1'b0;
      taken      = ~entry_free;
      for (int i = 0; i < NUM_BANKS; i++) begin
         b = lane_bank[i*BW +: BW];
         if (!stop) begin
            if (!lane_valid[i]) begin
               stop = 1'b1;
            end else if (taken[b]) begin
               conflict = 1'b1;
               stop     = 1'b1;
            end else begin
               lane_ready[i]          = 1'b1;
               taken[b]               = 1'b1;
               bank_push[b]           = 1'b1;
               bank_lane[b*BW +: BW]  = BW'(i);
               accepted               = accepted + CW'(1);
            end
         end
      end
   end

   always_comb begin
      if (conflict)
         stall = ST_CONFLICT;
      else if ((&lane_ready) && backlog)
         stall = ST_COAL;
      else
         stall = ST_NONE;
   end
endmodule

// File: rtl/bhd_delay_line.sv
module bhd_delay_line #(
   parameter int LATENCY = 3,
   parameter int EW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] push_data,
   input  logic          head_done,
   output logic          entry_free,
   output logic          head_valid,
   output logic [EW-1:0] head_data
);
   logic          slot_v [LATENCY];
   logic [EW-1:0] slot_d [LATENCY];
   logic [LATENCY-1:0] hole;

   // hole[k]: some slot at or below k is vacant after this cycle's lookup,
   // so slot k takes the content of slot k+1
   always_comb begin
      hole[0] = !slot_v[0] || head_done;
      for (int k = 1; k < LATENCY; k++)
         hole[k] = hole[k-1] || !slot_v[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < LATENCY; k++)
            slot_v[k] <= 1'b0;
      end else begin
         for (int k = 0; k < LATENCY-1; k++)
            if (hole[k]) slot_v[k] <= slot_v[k+1];
         if (hole[LATENCY-1]) slot_v[LATENCY-1] <= push;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LATENCY-1; k++)
         if (hole[k]) slot_d[k] <= slot_d[k+1];
      if (hole[LATENCY-1]) slot_d[LATENCY-1] <= push_data;
   end

   assign entry_free = !slot_v[LATENCY-1];
   assign head_valid = slot_v[0];
   assign head_data  = slot_d[0];
endmodule

// File: rtl/bank_hit_delay.sv
module bank_hit_delay
   import bhd_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int LATENCY     = 3,
   parameter int ADDR_W      = 16,
   parameter int TAG_W       = 8,
   parameter int SIZE_W      = 8,
   parameter int CNT_W       = 8,
   parameter int SECTOR_MODE = 1,
   parameter int SECTOR_LOG2 = 5,
   parameter int LINE_LOG2   = 7
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_BANKS-1:0]              req_valid,
   input  logic [NUM_BANKS*ADDR_W-1:0]       req_addr,
   input  logic [NUM_BANKS*TAG_W-1:0]        req_tag,
   input  logic [NUM_BANKS-1:0]              req_store,
   input  logic [NUM_BANKS*SIZE_W-1:0]       req_size,
   input  logic                              req_backlog,
   output logic [NUM_BANKS-1:0]              req_ready,
   output logic [$clog2(NUM_BANKS+1)-1:0]    acc_count,
   output logic [1:0]                        issue_stall,
   output logic [NUM_BANKS-1:0]              lk_valid,
   output logic [NUM_BANKS*ADDR_W-1:0]       lk_addr,
   output logic [NUM_BANKS*TAG_W-1:0]        lk_tag,
   output logic [NUM_BANKS-1:0]              lk_store,
   input  logic [NUM_BANKS*2-1:0]            lk_status,
   input  logic [NUM_BANKS-1:0]              lk_wr_sent,
   output logic [CNT_W-1:0]                  store_pend
);
   localparam int BW = $clog2(NUM_BANKS);
   localparam int EW = SIZE_W + 1 + TAG_W + ADDR_W;

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("LATENCY must be at least 1");
      end
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS-1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (ADDR_W < LINE_LOG2 + BW || ADDR_W < SECTOR_LOG2 + BW) begin : g_bad_addr
         $error("ADDR_W too narrow for bank selection");
      end
   endgenerate

   logic [NUM_BANKS*BW-1:0] lane_bank;
   logic [NUM_BANKS-1:0]    entry_free;
   logic [NUM_BANKS-1:0]    bank_push;
   logic [NUM_BANKS*BW-1:0] bank_lane;
   logic [NUM_BANKS-1:0]    head_done;
   logic [NUM_BANKS-1:0]    head_ack;
   logic [EW-1:0]           lane_ent [NUM_BANKS];
   logic [EW-1:0]           head_ent [NUM_BANKS];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_lane
         bhd_bank_sel #(
            .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SECTOR_MODE(SECTOR_MODE),
            .SECTOR_LOG2(SECTOR_LOG2), .LINE_LOG2(LINE_LOG2)
         ) u_sel (
            .addr (req_addr[gi*ADDR_W +: ADDR_W]),
            .bank (lane_bank[gi*BW +: BW])
         );
         assign lane_ent[gi] = {req_size[gi*SIZE_W +: SIZE_W], req_store[gi],
                                req_tag[gi*TAG_W +: TAG_W], req_addr[gi*ADDR_W +: ADDR_W]};
      end
   endgenerate

   bhd_issue #(.NUM_BANKS(NUM_BANKS)) u_issue (
      .lane_valid (req_valid),
      .lane_bank  (lane_bank),
      .entry_free (entry_free),
      .backlog    (req_backlog),
      .lane_ready (req_ready),
      .accepted   (acc_count),
      .stall      (issue_stall),
      .bank_push  (bank_push),
      .bank_lane  (bank_lane)
   );

   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         logic [1:0] st;
         assign st = lk_status[gi*2 +: 2];
         assign head_done[gi] = lk_valid[gi] && (st != LK_RSVFAIL);
         assign head_ack[gi]  = lk_valid[gi] && (st == LK_HIT) && lk_store[gi] && !lk_wr_sent[gi];

         bhd_delay_line #(.LATENCY(LATENCY), .EW(EW)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (bank_push[gi]),
            .push_data  (lane_ent[bank_lane[gi*BW +: BW]]),
            .head_done  (head_done[gi]),
            .entry_free (entry_free[gi]),
            .head_valid (lk_valid[gi]),
            .head_data  (head_ent[gi])
         );
         assign lk_addr[gi*ADDR_W +: ADDR_W] = head_ent[gi][ADDR_W-1:0];
         assign lk_tag[gi*TAG_W +: TAG_W]    = head_ent[gi][ADDR_W +: TAG_W];
         assign lk_store[gi]                 = head_ent[gi][ADDR_W+TAG_W];
      end
   endgenerate

   // store acknowledgement accounting
   function automatic logic [CNT_W-1:0] ack_amount(input logic [SIZE_W-1:0] sz);
      if (SECTOR_MODE != 0) return CNT_W'(sz >> SECTOR_LOG2);
      else                  return CNT_W'(1);
   endfunction

   logic [CNT_W-1:0] inc_sum, dec_sum;
   always_comb begin
      inc_sum = '0;
      dec_sum = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (req_ready[i] && req_store[i])
            inc_sum = inc_sum + ack_amount(req_size[i*SIZE_W +: SIZE_W]);
         if (head_ack[i])
            dec_sum = dec_sum + ack_amount(head_ent[i][EW-1 -: SIZE_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) store_pend <= '0;
      else        store_pend <= store_pend + inc_sum - dec_sum;
   end
endmodule

// File: rtl/bhd_checker.sv
module bhd_checker #(
   parameter int NUM_BANKS = 4,
   parameter int TAG_W     = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_BANKS-1:0]           req_valid,
   input logic [NUM_BANKS-1:0]           req_ready,
   input logic                           req_backlog,
   input logic [$clog2(NUM_BANKS+1)-1:0] acc_count,
   input logic [1:0]                     issue_stall,
   input logic [NUM_BANKS-1:0]           lk_valid,
   input logic [NUM_BANKS*TAG_W-1:0]     lk_tag,
   input logic [NUM_BANKS*2-1:0]         lk_status
);
   a_r3_ready_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_ready) == int'(acc_count));

   a_r3_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);

   a_r4_conflict_short: assert property (@(posedge clk) disable iff (!rst_n)
      issue_stall == 2'd1 |-> int'(acc_count) < $countones(req_valid));

   a_r5_coal_full: assert property (@(posedge clk) disable iff (!rst_n)
      issue_stall == 2'd2 |-> (int'(acc_count) == NUM_BANKS) && req_backlog);

   genvar gb;
   generate
      for (gb = 0; gb < NUM_BANKS; gb++) begin : g_hold
         a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_valid[gb] && lk_status[gb*2 +: 2] == 2'd2)
            |=> (lk_valid[gb] && $stable(lk_tag[gb*TAG_W +: TAG_W])));
      end
   endgenerate
endmodule

bind bank_hit_delay bhd_checker #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_backlog (req_backlog),
   .acc_count   (acc_count),
   .issue_stall (issue_stall),
   .lk_valid    (lk_valid),
   .lk_tag      (lk_tag),
   .lk_status   (lk_status)
);

// File: tb/bank_hit_delay_tb.sv
`timescale 1ns/1ps
module bank_hit_delay_tb;
   localparam int NB = 4, LAT = 3, AW = 16, TW = 8, SW = 8, CNTW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NB-1:0]    req_valid = '0;
   logic [NB*AW-1:0] req_addr  = '0;
   logic [NB*TW-1:0] req_tag   = '0;
   logic [NB-1:0]    req_store = '0;
   logic [NB*SW-1:0] req_size  = '0;
   logic             req_backlog = 1'b0;
   logic [NB*2-1:0]  lk_status = '0;
   logic [NB-1:0]    lk_wr_sent = '0;

   logic [NB-1:0] s_ready, l_ready, s_lkv, l_lkv, s_lks, l_lks;
   logic [2:0] s_acc, l_acc;
   logic [1:0] s_stall, l_stall;
   logic [NB*AW-1:0] s_lka, l_lka;
   logic [NB*TW-1:0] s_lkt, l_lkt;
   logic [CNTW-1:0] s_pend, l_pend;

   bank_hit_delay #(.NUM_BANKS(NB), .LATENCY(LAT), .ADDR_W(AW), .TAG_W(TW), .SIZE_W(SW),
      .CNT_W(CNTW), .SECTOR_MODE(1), .SECTOR_LOG2(5), .LINE_LOG2(7)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
      .req_store(req_store), .req_size(req_size), .req_backlog(req_backlog),
      .req_ready(s_ready), .acc_count(s_acc), .issue_stall(s_stall),
      .lk_valid(s_lkv), .lk_addr(s_lka), .lk_tag(s_lkt), .lk_store(s_lks),
      .lk_status(lk_status), .lk_wr_sent(lk_wr_sent), .store_pend(s_pend));

   bank_hit_delay #(.NUM_BANKS(NB), .LATENCY(LAT), .ADDR_W(AW), .TAG_W(TW), .SIZE_W(SW),
      .CNT_W(CNTW), .SECTOR_MODE(0), .SECTOR_LOG2(5), .LINE_LOG2(7)) u_dut_line (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
      .req_store(req_store), .req_size(req_size), .req_backlog(req_backlog),
      .req_ready(l_ready), .acc_count(l_acc), .issue_stall(l_stall),
      .lk_valid(l_lkv), .lk_addr(l_lka), .lk_tag(l_lkt), .lk_store(l_lks),
      .lk_status(lk_status), .lk_wr_sent(lk_wr_sent), .store_pend(l_pend));

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input string rq, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic set_lane(input int i, input int addr, input int tag, input bit st, input int sz);
      req_addr[i*AW +: AW] = AW'(addr);
      req_tag[i*TW +: TW]  = TW'(tag);
      req_store[i]         = st;
      req_size[i*SW +: SW] = SW'(sz);
   endtask

   task automatic set_all_status(input logic [1:0] st, input bit wr);
      for (int b = 0; b < NB; b++) lk_status[b*2 +: 2] = st;
      lk_wr_sent = wr ? '1 : '0;
   endtask

   // offer one request on lane 0 until it is taken; returns at the
   // falling edge after the accepting edge with the lane released
   task automatic push(input int addr, input int tag, input bit st, input int sz);
      @(negedge clk);
      set_lane(0, addr, tag, st, sz);
      req_valid = 4'b0001;
      for (int k = 0; k < 30; k++) begin
         #1;
         if (s_ready[0]) break;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 lk_valid after reset", int'(s_lkv), 0);
      check("R9 stall idle", int'(s_stall), 0);
      check("R9 store_pend zero", int'(s_pend), 0);
      check("R9 acc idle", int'(s_acc), 0);
   endtask

   task automatic t_fill_all_banks();
      int bk [4] = '{2, 0, 3, 1};
      set_all_status(2'd1, 1'b0);
      @(negedge clk);
      for (int i = 0; i < NB; i++) set_lane(i, bk[i] << 5, 10 + i, 1'b0, 0);
      req_valid = 4'b1111;
      #1;
      check("R3 four lanes accepted", int'(s_acc), 4);
      check("R3 ready all", int'(s_ready), 15);
      check("R5 no stall without backlog", int'(s_stall), 0);
      check("R1 line mode all to bank0 acc", int'(l_acc), 1);
      check("R4 line mode same-cycle conflict", int'(l_stall), 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = '0;
      repeat (LAT-1) @(posedge clk);
      @(negedge clk);
      check("R2 all heads valid after LAT", int'(s_lkv), 15);
      check("R2 bank0 tag", int'(s_lkt[0*TW +: TW]), 11);
      check("R2 bank3 tag", int'(s_lkt[3*TW +: TW]), 12);
      check("R2 bank1 addr", int'(s_lka[1*AW +: AW]), 32);
      check("R1 line head bank0 only", int'(l_lkv), 1);
      check("R2 line bank0 tag", int'(l_lkt[0 +: TW]), 10);
      @(posedge clk);
      @(negedge clk);
      check("R6 miss retires heads", int'(s_lkv), 0);
   endtask

   task automatic t_line_vs_sector();
      set_all_status(2'd0, 1'b0);
      push(32'h1A0, 20, 1'b1, 64);
      check("R8 sector store inc size>>5", int'(s_pend), 2);
      check("R8 line store inc one", int'(l_pend), 1);
      repeat (LAT-1) @(posedge clk);
      @(negedge clk);
      check("R1 sector bank select", int'(s_lkv), 2);
      check("R1 line bank select", int'(l_lkv), 8);
      @(posedge clk);
      @(negedge clk);
      check("R8 sector hit no-write dec", int'(s_pend), 0);
      check("R8 line hit no-write dec", int'(l_pend), 0);
   endtask

   task automatic t_rsv_hold();
      set_all_status(2'd2, 1'b0);
      push(0, 30, 1'b0, 0);
      push(0, 31, 1'b0, 0);
      push(0, 32, 1'b0, 0);
      set_lane(0, 0, 33, 1'b0, 0);
      req_valid = 4'b0001;
      for (int c = 0; c < 4; c++) begin
         #1;
         check("R4 occupied entry slot conflict", int'(s_stall), 1);
         check("R4 nothing accepted", int'(s_acc), 0);
         check("R6 head held", int'(s_lkv[0]), 1);
         check("R6 head tag held", int'(s_lkt[0 +: TW]), 30);
         @(negedge clk);
      end
      req_valid = '0;
      set_all_status(2'd0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R7 second entry at head", int'(s_lkt[0 +: TW]), 31);
      @(posedge clk);
      @(negedge clk);
      check("R7 third entry at head", int'(s_lkt[0 +: TW]), 32);
      @(posedge clk);
      @(negedge clk);
      check("R7 line drained", int'(s_lkv), 0);
   endtask

   task automatic t_issue_status();
      @(negedge clk);
      for (int i = 0; i < NB; i++) set_lane(i, i << 5, 50 + i, 1'b0, 0);
      req_valid = 4'b1111;
      req_backlog = 1'b1;
      #1;
      check("R5 coalescing stall", int'(s_stall), 2);
      check("R5 all taken", int'(s_acc), 4);
      #1;
      set_lane(1, 0, 51, 1'b0, 0);
      #1;
      check("R4 conflict wins over backlog", int'(s_stall), 1);
      check("R4 prefix stops at lane1", int'(s_ready), 1);
      #1;
      req_valid = 4'b0001;
      req_backlog = 1'b0;
      #1;
      check("R5 partial window no stall", int'(s_stall), 0);
      check("R3 single lane count", int'(s_acc), 1);
      #1;
      req_valid = '0;
   endtask

   task automatic t_store_count();
      set_all_status(2'd1, 1'b0);
      push(32'h20, 40, 1'b1, 96);
      check("R8 inc three", int'(s_pend), 3);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      check("R8 miss keeps count", int'(s_pend), 3);
      set_all_status(2'd0, 1'b1);
      push(32'h20, 41, 1'b1, 32);
      check("R8 inc one", int'(s_pend), 4);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      check("R8 write-through hit keeps count", int'(s_pend), 4);
      set_all_status(2'd0, 1'b0);
      push(32'h20, 42, 1'b1, 96);
      check("R8 inc to seven", int'(s_pend), 7);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      check("R8 hit dec by three", int'(s_pend), 4);
      check("R8 line mode count", int'(l_pend), 2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_all_banks();
      t_line_vs_sector();
      t_rsv_hold();
      t_issue_status();
      t_store_count();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule